// File: doc/BRIEF.md
# Triple-Match Timer Counter Channel

This block is a single 16-bit timer channel running on the system clock. An optional power-of-two prescaler sets the rate at which the count moves. The count can step upward or downward. Its span is either the full 16-bit range or a programmable ceiling. When the count passes either end of its span it wraps, and a wrap event is reported on one of two flags, depending on which span is active.

Three match comparators watch the count in parallel. Each one pulses its own flag when the count lands on its match value. A one-clock clear input returns the count to zero. Every flag output is a one-clock pulse, aligned with the count value that caused it. Whatever logic collects these pulses into sticky status bits and raises an interrupt is outside this block.

Top module: `tc_triple_match_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `count` = 0, `flags` = 0 and `tick` = 0.
- R2: When `clk_cfg[0]` = 0, `tick` is high on every cycle in which the channel runs. When `clk_cfg[0]` = 1 with N = `clk_cfg[4:1]`, `tick` is high on one cycle out of every 2^(N+1). The count changes only at the edge that ends a cycle in which `tick` is high.
- R3: With `cnt_cfg[1]` = 0, the span is 0 to 0xFFFF. Counting up from 0xFFFF gives 0, and counting down from 0 gives 0xFFFF. Each such wrap pulses `flags[4]` (overflow).
- R4: With `cnt_cfg[1]` = 1, the span is 0 to `interval` inclusive. Counting up from a count at or above `interval` gives 0 and pulses `flags[0]` (interval wrap). In this mode `flags[4]` stays low.
- R5: With `cnt_cfg[2]` = 1, the count decrements. A step from 0 loads the top of the active span and pulses that span's wrap flag.
- R6: With `cnt_cfg[3]` = 1, a step that makes the count equal to match value k pulses `flags[k+1]` for one cycle, in the same cycle that shows the new count. Match value k is `match_vals[16k+15:16k]`, for k = 0, 1, 2.
- R7: A match value greater than the top of the active span never pulses its flag, even if the count reaches that value.
- R8: With `cnt_cfg[3]` = 0, `flags[3:1]` stay low.
- R9: A cycle with `clear` high sets `count` to 0 and restarts the prescaler. Once `clear` falls, counting resumes from 0.
- R10: With `cnt_cfg[0]` = 1, the count holds its value, `tick` is low and `flags` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_cfg | input | 5 | Bit 0 enables the prescaler; bits 4:1 hold the divide exponent N |
| cnt_cfg | input | 4 | Bit 0 stops the channel, bit 1 selects the interval span, bit 2 selects downward counting, bit 3 enables matching |
| clear | input | 1 | One-cycle pulse that zeroes the count and the prescaler |
| interval | input | 16 | Top of the span in interval mode |
| match_vals | input | 48 | Three packed 16-bit match values, value 0 in the low bits |
| count | output | 16 | Current count |
| flags | output | 5 | One-cycle event pulses: bit 0 interval wrap, bits 3:1 matches, bit 4 overflow |
| tick | output | 1 | High in cycles whose closing edge advances the count |

## Verification
The checker runs on every cycle. It covers the behaviour of reset and clear, and it confirms that a stopped channel holds its count and stays silent. It also confirms that an unprescaled running channel ticks on every clock, and that no flag appears without a tick in the cycle before it. For each flag it checks the source: a match flag needs matching enabled, a count equal to that match value, and a value inside the span; a wrap flag needs the span and end value that its mode implies.

The bench's scenarios are the only place where the exact prescaler rhythm is checked over many cycles. They also show the full 65,536-step overflow walk, a count left above a newly narrowed interval draining down without a match, and the point where counting resumes after a clear.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
// tc_pkg: shared field positions and the decoded mode record for the timer channel.
// Assumes the counter-control field is 4 bits wide with the layout given below.
package tc_pkg;
    // counter-control field bit positions
    localparam int CTL_STOP = 0;
    localparam int CTL_IVL  = 1;
    localparam int CTL_DOWN = 2;
    localparam int CTL_MEN  = 3;
    localparam int CTL_W    = 4;

    // clock-control field: bit 0 enables prescaling, the exponent sits above it
    localparam int CLK_PS_EN = 0;

    // flag vector: bit 0 interval wrap, then one bit per match, then overflow
    localparam int FLG_IVL = 0;

    typedef struct packed {
        logic stop;
        logic ivl;
        logic down;
        logic men;
    } tc_mode_t;

    // Split the raw counter-control field into named mode bits.
    function automatic tc_mode_t decode_mode(input logic [CTL_W-1:0] raw);
        tc_mode_t m;
        m.stop = raw[CTL_STOP];
        m.ivl  = raw[CTL_IVL];
        m.down = raw[CTL_DOWN];
        m.men  = raw[CTL_MEN];
        return m;
    endfunction
endpackage

// File: rtl/tc_prescaler.sv
`timescale 1ns/1ps
// tc_prescaler: produces the advance strobe for the channel.
// With prescaling off the strobe follows 'run' on every clock. With it on, the
// strobe fires once every 2^(sel+1) running clocks. Leaving 'run' low restarts
// the division. The terminal test uses >= so that a smaller exponent written
// mid-period takes effect on the next clock instead of waiting for a wrap.
module tc_prescaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ps_en,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** SEL_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] last;

    // Terminal divider value: 2^(sel+1)-1 when enabled, zero when bypassed.
    always_comb begin
        span = (DIV_W+1)'(1) << ({1'b0, ps_sel} + (SEL_W+1)'(1));
        last = ps_en ? DIV_W'(span - (DIV_W+1)'(1)) : '0;
    end

    assign tick = run & (div_q >= last);

    // Divider state: restart when idle or on the strobe, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tc_count_core.sv
`timescale 1ns/1ps
// tc_count_core: the count register and its next-value logic.
// Counting up, a count at or above 'top' returns to zero. Counting down, zero
// loads 'top'. 'wrap' reports the end crossing for the step being decided now.
// Assumes 'step' is already low while cleared or stopped.
module tc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         down,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    // Next value and end-crossing detection for the current direction.
    always_comb begin
        wrap       = 1'b0;
        next_count = cnt_q;
        if (down) begin
            if (cnt_q == '0) begin
                next_count = top;
                wrap       = 1'b1;
            end else begin
                next_count = cnt_q - W'(1);
            end
        end else begin
            if (cnt_q >= top) begin
                next_count = '0;
                wrap       = 1'b1;
            end else begin
                next_count = cnt_q + W'(1);
            end
        end
    end

    // Count register: zeroed by reset or clear, advanced only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= next_count;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tc_match_bank.sv
`timescale 1ns/1ps
// tc_match_bank: NM parallel comparators against the value the count is about to take.
// A comparator hits only when matching is enabled and its value lies inside the
// active span. Hits are combinational; the caller registers them with the count.
module tc_match_bank #(
    parameter int W  = 16,
    parameter int NM = 3
) (
    input  logic            men,
    input  logic [W-1:0]    top,
    input  logic [W-1:0]    next_count,
    input  logic [NM*W-1:0] match_vals,
    output logic [NM-1:0]   hits
);
    for (genvar k = 0; k < NM; k++) begin : g_cmp
        logic [W-1:0] mv;
        // One comparator: equal to the next count and not beyond the span top.
        always_comb begin
            mv      = match_vals[k*W +: W];
            hits[k] = men && (mv <= top) && (mv == next_count);
        end
    end
endmodule

// File: rtl/tc_triple_match_timer.sv
`timescale 1ns/1ps
// tc_triple_match_timer: one timer channel with a prescaler, a selectable span,
// a selectable direction and NM match comparators. Flags are one-cycle pulses
// registered together with the count, so each pulse is seen alongside the count
// value that caused it. Reset is synchronous and active low.
module tc_triple_match_timer
    import tc_pkg::*;
#(
    parameter int W     = 16,
    parameter int NM    = 3,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W:0]    clk_cfg,
    input  logic [CTL_W-1:0]  cnt_cfg,
    input  logic              clear,
    input  logic [W-1:0]      interval,
    input  logic [NM*W-1:0]   match_vals,
    output logic [W-1:0]      count,
    output logic [NM+1:0]     flags,
    output logic              tick
);
    localparam int FW      = NM + 2;
    localparam int FLG_OVF = NM + 1;

    tc_mode_t      mode;
    logic          run;
    logic          step;
    logic [W-1:0]  top_val;
    logic [W-1:0]  next_count;
    logic          wrap;
    logic [NM-1:0] hits;
    logic [FW-1:0] flags_q;
    logic [FW-1:0] flags_d;

    assign mode = decode_mode(cnt_cfg);
    assign run  = rst_n & ~mode.stop & ~clear;

    // Active span top: the programmed interval, or every bit set for full range.
    always_comb begin
        top_val = mode.ivl ? interval : {W{1'b1}};
    end

    tc_prescaler #(.SEL_W(SEL_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ps_en  (clk_cfg[CLK_PS_EN]),
        .ps_sel (clk_cfg[SEL_W:1]),
        .tick   (step)
    );

    tc_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .step       (step),
        .down       (mode.down),
        .top        (top_val),
        .count      (count),
        .next_count (next_count),
        .wrap       (wrap)
    );

    tc_match_bank #(.W(W), .NM(NM)) u_match (
        .men        (mode.men),
        .top        (top_val),
        .next_count (next_count),
        .match_vals (match_vals),
        .hits       (hits)
    );

    // Flag vector for this step: wrap routed by span mode, matches in the middle.
    always_comb begin
        flags_d          = '0;
        flags_d[FLG_IVL] = wrap & mode.ivl;
        flags_d[FLG_OVF] = wrap & ~mode.ivl;
        flags_d[NM:1]    = hits;
    end

    // Flag register: pulses last one cycle and appear only after a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags_q <= '0;
        end else if (step) begin
            flags_q <= flags_d;
        end else begin
            flags_q <= '0;
        end
    end

    assign flags = flags_q;
    assign tick  = step;
endmodule

// File: rtl/tc_timer_checker.sv
`timescale 1ns/1ps
// tc_timer_checker: cycle-level properties of the timer channel, seen only at its ports.
module tc_timer_checker #(
    parameter int W     = 16,
    parameter int NM    = 3,
    parameter int SEL_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SEL_W:0]  clk_cfg,
    input logic [3:0]      cnt_cfg,
    input logic            clear,
    input logic [W-1:0]    interval,
    input logic [NM*W-1:0] match_vals,
    input logic [W-1:0]    count,
    input logic [NM+1:0]   flags,
    input logic            tick
);
    localparam int OVF = NM + 1;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && flags == '0));
    a_r1_no_tick_in_reset: assert property (@(posedge clk)
        !rst_n |-> !tick);

    a_r2_tick_each_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_cfg[0] && !cnt_cfg[0] && !clear) |-> tick);
    a_r2_flag_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0) |-> $past(tick));

    a_r3_ovf_in_full_span: assert property (@(posedge clk) disable iff (!rst_n)
        flags[OVF] |-> !$past(cnt_cfg[1]));
    a_r3_ovf_down_top: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[OVF] && $past(cnt_cfg[2])) |-> count == {W{1'b1}});

    a_r4_ivl_in_ivl_span: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] |-> $past(cnt_cfg[1]));
    a_r4_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags[0] || flags[OVF]) && !$past(cnt_cfg[2])) |-> count == '0);

    a_r5_down_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && $past(cnt_cfg[2])) |-> count == $past(interval));

    for (genvar k = 0; k < NM; k++) begin : g_m
        a_r6_hit_value: assert property (@(posedge clk) disable iff (!rst_n)
            flags[k+1] |-> count == $past(match_vals[k*W +: W]));
        a_r7_hit_in_span: assert property (@(posedge clk) disable iff (!rst_n)
            flags[k+1] |-> (!$past(cnt_cfg[1]) ||
                            $past(match_vals[k*W +: W]) <= $past(interval)));
        a_r8_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            flags[k+1] |-> $past(cnt_cfg[3]));
    end

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && flags == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cfg[0] && !clear) |=> $stable(count));
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cfg[0] |=> flags == '0);
    a_r10_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cfg[0] |-> !tick);
endmodule

bind tc_triple_match_timer tc_timer_checker #(.W(W), .NM(NM), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_cfg    (clk_cfg),
    .cnt_cfg    (cnt_cfg),
    .clear      (clear),
    .interval   (interval),
    .match_vals (match_vals),
    .count      (count),
    .flags      (flags),
    .tick       (tick)
);

// File: tb/sim_tc_triple_match_timer.sv
`timescale 1ns/1ps
// Scoreboard bench: a behavioural model built from the requirements queues one
// expected record per clock; a monitor pops each record and compares it with the ports.
module sim_tc_triple_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  clk_cfg = '0;
    logic [3:0]  cnt_cfg = '0;
    logic        clear = 1'b0;
    logic [15:0] interval = '0;
    logic [47:0] match_vals = '0;
    logic [15:0] count;
    logic [4:0]  flags;
    logic        tick;

    always #10 clk = ~clk;

    tc_triple_match_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_cfg    (clk_cfg),
        .cnt_cfg    (cnt_cfg),
        .clear      (clear),
        .interval   (interval),
        .match_vals (match_vals),
        .count      (count),
        .flags      (flags),
        .tick       (tick)
    );

    typedef struct {
        logic [15:0] c;
        logic [4:0]  f;
        logic        t;
        string       tag;
    } exp_t;

    exp_t  sbq[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1 reset";
    int    m_cnt = 0;
    int    m_div = 0;

    // Model: the requirements applied to the inputs seen at each rising edge.
    always @(posedge clk) begin : model
        int          top;
        int          per;
        int          nxt;
        bit          fire;
        bit          wrapped;
        logic [4:0]  mflg;
        logic [15:0] mv;
        exp_t        e;
        top  = cnt_cfg[1] ? int'(interval) : 65535;
        per  = clk_cfg[0] ? (1 << (int'(clk_cfg[4:1]) + 1)) : 1;
        mflg = '0;
        if (!rst_n || clear) begin
            m_cnt = 0;
            m_div = 0;
        end else if (cnt_cfg[0]) begin
            m_div = 0;
        end else begin
            fire  = (m_div >= per - 1);
            m_div = fire ? 0 : m_div + 1;
            if (fire) begin
                wrapped = 1'b0;
                if (cnt_cfg[2]) begin
                    if (m_cnt == 0) begin nxt = top; wrapped = 1'b1; end
                    else nxt = m_cnt - 1;
                end else begin
                    if (m_cnt >= top) begin nxt = 0; wrapped = 1'b1; end
                    else nxt = m_cnt + 1;
                end
                if (wrapped) mflg[cnt_cfg[1] ? 0 : 4] = 1'b1;
                for (int i = 0; i < 3; i++) begin
                    mv = match_vals[i*16 +: 16];
                    if (cnt_cfg[3] && int'(mv) <= top && int'(mv) == nxt) mflg[i+1] = 1'b1;
                end
                m_cnt = nxt;
            end
        end
        e.c   = 16'(m_cnt);
        e.f   = mflg;
        e.t   = rst_n && !cnt_cfg[0] && !clear && (m_div >= per - 1);
        e.tag = tag;
        sbq.push_back(e);
    end

    // Monitor: compare each queued record with the ports, mid-cycle.
    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                total++;
                if (count !== e.c || flags !== e.f || tick !== e.t) begin
                    bad++;
                    $display("FAIL %s: count=%h flags=%b tick=%b expected count=%h flags=%b tick=%b",
                             e.tag, count, flags, tick, e.c, e.f, e.t);
                end
            end
        end
    end

    task automatic drive(input string t, input logic [4:0] ck, input logic [3:0] cc,
                         input logic [15:0] iv, input logic [15:0] m0,
                         input logic [15:0] m1, input logic [15:0] m2);
        @(negedge clk);
        tag        = t;
        clk_cfg    = ck;
        cnt_cfg    = cc;
        interval   = iv;
        match_vals = {m2, m1, m0};
    endtask

    task automatic pulse_clear(input string t);
        @(negedge clk);
        tag   = t;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : stimulus
        // R1: reset state
        wait_cyc(3);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: prescaler bypassed, then divide by 2 and by 8
        drive("R2 tick every clock", 5'b00000, 4'b0010, 16'd9, 16'd0, 16'd0, 16'd0);
        wait_cyc(20);
        drive("R2 divide by 2", 5'b00001, 4'b0010, 16'd9, 16'd0, 16'd0, 16'd0);
        wait_cyc(20);
        drive("R2 divide by 8", 5'b00101, 4'b0010, 16'd9, 16'd0, 16'd0, 16'd0);
        wait_cyc(50);
        // R4 and R6: interval span counting up with three matches, one at the top
        drive("R4 R6 interval up with matches", 5'b00000, 4'b1010, 16'd9, 16'd3, 16'd7, 16'd9);
        wait_cyc(40);
        // R8: same values with matching disabled
        drive("R8 matching disabled", 5'b00000, 4'b0010, 16'd9, 16'd3, 16'd7, 16'd9);
        wait_cyc(25);
        // R5: downward interval span, match on zero
        drive("R5 interval down", 5'b00000, 4'b1110, 16'd6, 16'd2, 16'd5, 16'd0);
        wait_cyc(30);
        // R10: stopped channel holds, then resumes
        drive("R10 stopped", 5'b00000, 4'b1111, 16'd6, 16'd2, 16'd5, 16'd0);
        wait_cyc(15);
        drive("R10 resumed", 5'b00000, 4'b1110, 16'd6, 16'd2, 16'd5, 16'd0);
        wait_cyc(10);
        // R9: clear mid-run, then resume from zero
        pulse_clear("R9 clear");
        wait_cyc(12);
        // R7: climb past 12 in full span, then narrow the span to 9 and drain downward
        pulse_clear("R7 setup clear");
        drive("R7 setup climb", 5'b00000, 4'b1000, 16'd0, 16'd100, 16'd200, 16'd12);
        wait_cyc(16);
        drive("R7 match above interval", 5'b00000, 4'b1110, 16'd9, 16'd100, 16'd200, 16'd12);
        wait_cyc(30);
        // R3: full-range walk upward, then the downward wrap from zero
        pulse_clear("R3 setup clear");
        drive("R3 full range up", 5'b00000, 4'b1000, 16'd0, 16'hFFFF, 16'h8000, 16'd1);
        wait_cyc(65545);
        pulse_clear("R3 setup clear");
        drive("R3 full range down", 5'b00000, 4'b1100, 16'd0, 16'hFFFF, 16'h8000, 16'd1);
        wait_cyc(10);
        wait_cyc(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        #(64'd20 * 64'd200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run not complete, expected completion before limit");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule